// File: doc/BRIEF.md
# USB Host Transaction Result Evaluator

This block judges the outcome of one full-speed USB host transaction (SETUP, IN or OUT). Software-facing logic hands it the transaction kind, the data toggle the host expects to receive and the largest payload length it will accept, and pulses `start`. The transmit side reports when the host's own packet has left the wire. From then on the block times the device's reply and watches the decoded receive events from the packet layer: PID, PID check result, CRC result, framing error and payload length, all qualified by an end-of-packet strobe. It tells the transmit side when a handshake ACK is owed, and writes a result code. The code reads BUSY while the transaction is in flight. The block keeps no toggle state of its own. The expected toggle arrives with every transaction.

The control is a four-state machine. `ST_IDLE` waits for `start` and moves to `ST_HOST_TX`. `ST_HOST_TX` waits for `host_pkt_end` and moves to `ST_WAIT_RSP`. `ST_WAIT_RSP` counts bit times. From there `rx_active` leads to `ST_RECEIVE`, while a received end of packet or an expired timer returns the machine to `ST_IDLE`. `ST_RECEIVE` holds the timer frozen and returns to `ST_IDLE` on the end of packet. Each return to idle writes a final code together with a one-cycle `done` pulse.

Top module: `usb_txn_judge`

## Requirements
- R1: After reset `result` is 0 (SUCCESS), and `done`, `send_ack` and `nak_on_setup` are all 0.
- R2: Result codes are SUCCESS=0, BUSY=1, PKTERR=2, PIDERR=3, NAK=4, STALL=5, WRONGPID=6, CRCERR=7, TOGERR=8, BADLEN=9 and TIMEOUT=10. `result` reads BUSY from the cycle after an accepted `start` until the final code is written. `start` is accepted only when idle, and a `start` during a transaction has no effect on it.
- R3: A reply flagged with a framing (bit-stuff or EOP) error gives PKTERR, whatever its other flags say.
- R4: A reply without a framing error but with failing PID check bits gives PIDERR, whatever its CRC, length or PID value.
- R5: On SETUP or OUT (`txn_kind` 0 or 2), the handshake ACK (PID 4'b0010) gives SUCCESS, STALL (4'b1110) gives STALL and NAK (4'b1010) gives NAK. A data PID (DATA0 4'b0011, DATA1 4'b1011) gives WRONGPID.
- R6: A NAK to a SETUP sets `nak_on_setup`, which stays set until the next accepted `start`. A NAK to IN or OUT leaves it at 0.
- R7: On IN (`txn_kind` 1), a data packet with a bad CRC gives CRCERR, which ranks above a length error. A CRC-clean data packet with `rx_len` above `max_len` gives BADLEN, while a length equal to `max_len` is accepted.
- R8: On IN, a clean data packet whose toggle (DATA1=1) matches `exp_toggle` gives SUCCESS, and one that differs gives TOGERR. Both raise `send_ack`. No other outcome raises `send_ack`.
- R9: On IN, a NAK reply gives NAK, a STALL reply gives STALL, and an ACK reply gives WRONGPID.
- R10: With no reply, TIMEOUT is written on the clock edge of the 18th `bit_tick` counted in `ST_WAIT_RSP` after `host_pkt_end`. While `rx_active` holds the machine in `ST_RECEIVE`, no timeout occurs.
- R11: `done` is a single-cycle pulse that comes with every final code. `send_ack`, when raised, is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| txn_kind | input | 2 | 0 SETUP, 1 IN, 2 OUT |
| exp_toggle | input | 1 | Data toggle expected on IN |
| max_len | input | LEN_W | Largest accepted payload length |
| host_pkt_end | input | 1 | Host packet has finished on the wire |
| bit_tick | input | 1 | One full-speed bit time elapsed |
| rx_active | input | 1 | Packet layer is receiving a reply |
| rx_eop | input | 1 | Reply packet ended, fields below valid |
| rx_pid | input | 4 | Decoded PID of the reply |
| rx_pid_ok | input | 1 | PID check bits were consistent |
| rx_crc_ok | input | 1 | Data CRC was correct |
| rx_frame_err | input | 1 | Bit-stuff or EOP framing error |
| rx_len | input | LEN_W | Received payload byte count |
| result | output | 4 | Result code |
| done | output | 1 | Final code written this cycle |
| send_ack | output | 1 | Transmit side must send ACK |
| nak_on_setup | output | 1 | Last SETUP was answered with NAK |

## Verification
The bench runs each transaction kind against every reply class: handshake replies of each kind, data replies with matching and mismatching toggles, and replies carrying stacked error flags. The stacked flags separate framing from PID errors, PID errors from CRC errors, and CRC errors from length errors, so a wrong priority order shows up. Length checks use exactly `max_len` and one above it. A silent device separates the 17th bit tick from the 18th. A long reception shows whether the timer is frozen while `rx_active` holds. A second `start` issued mid-transaction, with a NAK reply to the original IN, shows whether the first kind was kept.

// File: rtl/usbj_pkg.sv
package usbj_pkg;

    typedef enum logic [1:0] {
        TXN_SETUP = 2'd0,
        TXN_IN    = 2'd1,
        TXN_OUT   = 2'd2
    } txn_kind_e;

    typedef enum logic [3:0] {
        RES_SUCCESS  = 4'd0,
        RES_BUSY     = 4'd1,
        RES_PKTERR   = 4'd2,
        RES_PIDERR   = 4'd3,
        RES_NAK      = 4'd4,
        RES_STALL    = 4'd5,
        RES_WRONGPID = 4'd6,
        RES_CRCERR   = 4'd7,
        RES_TOGERR   = 4'd8,
        RES_BADLEN   = 4'd9,
        RES_TIMEOUT  = 4'd10
    } res_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOST_TX,
        ST_WAIT_RSP,
        ST_RECEIVE
    } judge_state_e;

    localparam logic [3:0] PID_ACK   = 4'b0010;
    localparam logic [3:0] PID_NAK   = 4'b1010;
    localparam logic [3:0] PID_STALL = 4'b1110;
    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;

endpackage

// File: rtl/usbj_resp_timer.sv
module usbj_resp_timer #(
    parameter int LIMIT = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick && cnt != LAST) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign expired = tick && (cnt == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R10

endmodule

// File: rtl/usbj_classify.sv
module usbj_classify
    import usbj_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic [1:0]       kind,
    input  logic             exp_toggle,
    input  logic [LEN_W-1:0] max_len,
    input  logic [3:0]       pid,
    input  logic             pid_ok,
    input  logic             crc_ok,
    input  logic             frame_err,
    input  logic [LEN_W-1:0] len,
    output logic [3:0]       code,
    output logic             ack,
    output logic             nak_setup
);
    logic is_data;
    logic rx_toggle;

    assign is_data   = (pid == PID_DATA0) || (pid == PID_DATA1);
    assign rx_toggle = (pid == PID_DATA1);

    always_comb begin
        code      = RES_WRONGPID;
        ack       = 1'b0;
        nak_setup = 1'b0;
        if (frame_err) begin
            code = RES_PKTERR;
        end else if (!pid_ok) begin
            code = RES_PIDERR;
        end else if (pid == PID_NAK) begin
            code      = RES_NAK;
            nak_setup = (kind == TXN_SETUP);
        end else if (pid == PID_STALL) begin
            code = RES_STALL;
        end else if (kind == TXN_IN) begin
            if (!is_data) begin
                code = RES_WRONGPID;
            end else if (!crc_ok) begin
                code = RES_CRCERR;
            end else if (len > max_len) begin
                code = RES_BADLEN;
            end else if (rx_toggle != exp_toggle) begin
                code = RES_TOGERR;
                ack  = 1'b1;
            end else begin
                code = RES_SUCCESS;
                ack  = 1'b1;
            end
        end else begin
            code = (pid == PID_ACK) ? RES_SUCCESS : RES_WRONGPID;
        end
    end

endmodule

// File: rtl/usb_txn_judge.sv
module usb_txn_judge
    import usbj_pkg::*;
#(
    parameter int LEN_W        = 11,
    parameter int TIMEOUT_BITS = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       txn_kind,
    input  logic             exp_toggle,
    input  logic [LEN_W-1:0] max_len,
    input  logic             host_pkt_end,
    input  logic             bit_tick,
    input  logic             rx_active,
    input  logic             rx_eop,
    input  logic [3:0]       rx_pid,
    input  logic             rx_pid_ok,
    input  logic             rx_crc_ok,
    input  logic             rx_frame_err,
    input  logic [LEN_W-1:0] rx_len,
    output logic [3:0]       result,
    output logic             done,
    output logic             send_ack,
    output logic             nak_on_setup
);
    judge_state_e     state_q, state_d;
    logic [1:0]       kind_q;
    logic             tog_q;
    logic [LEN_W-1:0] max_q;
    logic [3:0]       result_q;
    logic             done_q, ack_q, nak_q;

    logic             tmr_clear, tmr_tick, tmr_expired;
    logic [3:0]       cls_code;
    logic             cls_ack, cls_nak;
    logic             listening, reply_end;

    assign listening = (state_q == ST_WAIT_RSP) || (state_q == ST_RECEIVE);
    assign reply_end = listening && rx_eop;
    assign tmr_clear = (state_q == ST_IDLE) || (state_q == ST_HOST_TX);
    assign tmr_tick  = (state_q == ST_WAIT_RSP) && bit_tick;

    usbj_resp_timer #(.LIMIT(TIMEOUT_BITS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .tick    (tmr_tick),
        .expired (tmr_expired)
    );

    usbj_classify #(.LEN_W(LEN_W)) u_classify (
        .kind       (kind_q),
        .exp_toggle (tog_q),
        .max_len    (max_q),
        .pid        (rx_pid),
        .pid_ok     (rx_pid_ok),
        .crc_ok     (rx_crc_ok),
        .frame_err  (rx_frame_err),
        .len        (rx_len),
        .code       (cls_code),
        .ack        (cls_ack),
        .nak_setup  (cls_nak)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_HOST_TX;
            ST_HOST_TX:  if (host_pkt_end) state_d = ST_WAIT_RSP;
            ST_WAIT_RSP: begin
                if (rx_eop || tmr_expired) state_d = ST_IDLE;
                else if (rx_active)        state_d = ST_RECEIVE;
            end
            ST_RECEIVE:  if (rx_eop) state_d = ST_IDLE;
        endcase
    end

    // Outputs and latched transaction parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= RES_SUCCESS;
            done_q   <= 1'b0;
            ack_q    <= 1'b0;
            nak_q    <= 1'b0;
            kind_q   <= TXN_SETUP;
            tog_q    <= 1'b0;
            max_q    <= '0;
        end else begin
            done_q <= 1'b0;
            ack_q  <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                result_q <= RES_BUSY;
                nak_q    <= 1'b0;
                kind_q   <= txn_kind;
                tog_q    <= exp_toggle;
                max_q    <= max_len;
            end else if (reply_end) begin
                result_q <= cls_code;
                done_q   <= 1'b1;
                ack_q    <= cls_ack;
                nak_q    <= cls_nak;
            end else if (state_q == ST_WAIT_RSP && tmr_expired) begin
                result_q <= RES_TIMEOUT;
                done_q   <= 1'b1;
            end
        end
    end

    assign result       = result_q;
    assign done         = done_q;
    assign send_ack     = ack_q;
    assign nak_on_setup = nak_q;

    AST_BUSY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (result_q == RES_BUSY)); // R2
    AST_DONE_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (result_q != RES_BUSY)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R11
    AST_ACK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (done_q && (result_q == RES_SUCCESS || result_q == RES_TOGERR))); // R8
    AST_NAKSETUP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        nak_q |-> (result_q == RES_NAK)); // R6
    AST_TIMEOUT_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && result_q == RES_TIMEOUT) |-> ($past(state_q) == ST_WAIT_RSP)); // R10

endmodule

// File: tb/tb_usb_txn_judge.sv
module tb_usb_txn_judge;
    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       txn_kind = 2'd0;
    logic             exp_toggle = 1'b0;
    logic [LEN_W-1:0] max_len = '0;
    logic             host_pkt_end = 1'b0;
    logic             bit_tick = 1'b1;
    logic             rx_active = 1'b0;
    logic             rx_eop = 1'b0;
    logic [3:0]       rx_pid = 4'd0;
    logic             rx_pid_ok = 1'b1;
    logic             rx_crc_ok = 1'b1;
    logic             rx_frame_err = 1'b0;
    logic [LEN_W-1:0] rx_len = '0;
    logic [3:0]       result;
    logic             done, send_ack, nak_on_setup;

    usb_txn_judge #(.LEN_W(LEN_W), .TIMEOUT_BITS(18)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .txn_kind(txn_kind),
        .exp_toggle(exp_toggle), .max_len(max_len), .host_pkt_end(host_pkt_end),
        .bit_tick(bit_tick), .rx_active(rx_active), .rx_eop(rx_eop),
        .rx_pid(rx_pid), .rx_pid_ok(rx_pid_ok), .rx_crc_ok(rx_crc_ok),
        .rx_frame_err(rx_frame_err), .rx_len(rx_len), .result(result),
        .done(done), .send_ack(send_ack), .nak_on_setup(nak_on_setup)
    );

    always #2 clk = ~clk;

    localparam logic [3:0] P_ACK = 4'b0010, P_NAK = 4'b1010, P_STALL = 4'b1110;
    localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011;
    localparam logic [1:0] K_SETUP = 2'd0, K_IN = 2'd1, K_OUT = 2'd2;
    localparam logic [3:0] C_OK = 4'd0, C_BUSY = 4'd1, C_PKT = 4'd2, C_PID = 4'd3,
                           C_NAK = 4'd4, C_STALL = 4'd5, C_WPID = 4'd6, C_CRC = 4'd7,
                           C_TOG = 4'd8, C_LEN = 4'd9, C_TMO = 4'd10;

    typedef struct {
        logic [3:0] code;
        logic       ack;
        logic       nak;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    int done_seen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(result == e.code, e.req, "result", int'(result), int'(e.code));
                check(send_ack == e.ack, e.req, "send_ack", int'(send_ack), int'(e.ack));
                check(nak_on_setup == e.nak, e.req, "nak_on_setup",
                      int'(nak_on_setup), int'(e.nak));
            end
        end
    end

    // Driver: one transaction with a reply
    task automatic txn(input logic [1:0] kind, input logic tog, input int maxl,
                       input int gap, input int act_len, input bit restart,
                       input logic [3:0] pid, input logic pok, input logic cok,
                       input logic ferr, input int len,
                       input logic [3:0] ecode, input logic eack, input logic enak,
                       input string req);
        exp_t e;
        e.code = ecode; e.ack = eack; e.nak = enak; e.req = req;
        exp_q.push_back(e);
        done_seen = 0;
        @(negedge clk);
        start = 1'b1; txn_kind = kind; exp_toggle = tog; max_len = LEN_W'(maxl);
        @(negedge clk);
        start = 1'b0;
        check(result == C_BUSY, "R2", "busy after start", int'(result), int'(C_BUSY));
        if (restart) begin
            start = 1'b1; txn_kind = K_SETUP; exp_toggle = ~tog;
            @(negedge clk);
            start = 1'b0;
        end
        host_pkt_end = 1'b1;
        @(negedge clk);
        host_pkt_end = 1'b0;
        repeat (gap) @(negedge clk);
        rx_active = 1'b1;
        repeat (act_len) @(negedge clk);
        rx_eop = 1'b1; rx_pid = pid; rx_pid_ok = pok; rx_crc_ok = cok;
        rx_frame_err = ferr; rx_len = LEN_W'(len);
        @(negedge clk);
        rx_eop = 1'b0; rx_active = 1'b0;
        rx_pid_ok = 1'b1; rx_crc_ok = 1'b1; rx_frame_err = 1'b0;
        repeat (3) @(negedge clk);
        check(done_seen == 1, "R11", "done pulses per transaction", done_seen, 1);
    endtask

    task automatic timeout_case();
        exp_t e;
        e.code = C_TMO; e.ack = 1'b0; e.nak = 1'b0; e.req = "R10";
        done_seen = 0;
        @(negedge clk);
        start = 1'b1; txn_kind = K_IN; exp_toggle = 1'b0; max_len = LEN_W'(64);
        @(negedge clk);
        start = 1'b0;
        host_pkt_end = 1'b1;
        @(negedge clk);
        host_pkt_end = 1'b0;
        repeat (17) @(negedge clk);
        check(result == C_BUSY && done_seen == 0, "R10", "still busy after 17 ticks",
              int'(result), int'(C_BUSY));
        exp_q.push_back(e);
        repeat (3) @(negedge clk);
        check(done_seen == 1, "R10", "timeout written on 18th tick", done_seen, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(result == C_OK, "R1", "reset result", int'(result), 0);
        check(!done && !send_ack && !nak_on_setup, "R1", "reset flags",
              int'({done, send_ack, nak_on_setup}), 0);

        // kind tog max gap act rst pid pok cok ferr len code ack nak req
        txn(K_OUT,   0, 64, 2, 2, 0, P_ACK,   1, 1, 0, 0,  C_OK,    0, 0, "R5");
        txn(K_SETUP, 0, 64, 2, 2, 0, P_STALL, 1, 1, 0, 0,  C_STALL, 0, 0, "R5");
        txn(K_OUT,   0, 64, 2, 2, 0, P_D0,    1, 1, 0, 0,  C_WPID,  0, 0, "R5");
        txn(K_OUT,   0, 64, 2, 2, 0, P_NAK,   1, 1, 0, 0,  C_NAK,   0, 0, "R6");
        txn(K_SETUP, 0, 64, 2, 2, 0, P_NAK,   1, 1, 0, 0,  C_NAK,   0, 1, "R6");
        check(nak_on_setup == 1'b1, "R6", "nak_on_setup held", int'(nak_on_setup), 1);
        txn(K_IN,    1, 8,  3, 4, 0, P_D1,    1, 1, 0, 8,  C_OK,    1, 0, "R8");
        txn(K_IN,    1, 8,  3, 4, 0, P_D0,    1, 1, 0, 8,  C_TOG,   1, 0, "R8");
        txn(K_IN,    0, 8,  3, 4, 0, P_D0,    1, 1, 0, 9,  C_LEN,   0, 0, "R7");
        txn(K_IN,    1, 8,  3, 4, 0, P_D0,    1, 0, 0, 9,  C_CRC,   0, 0, "R7");
        txn(K_IN,    1, 8,  3, 4, 0, P_D0,    0, 0, 1, 9,  C_PKT,   0, 0, "R3");
        txn(K_OUT,   0, 8,  3, 4, 0, P_ACK,   1, 1, 1, 0,  C_PKT,   0, 0, "R3");
        txn(K_IN,    1, 8,  3, 4, 0, P_D0,    0, 0, 0, 9,  C_PID,   0, 0, "R4");
        txn(K_IN,    0, 8,  3, 4, 0, P_ACK,   1, 1, 0, 0,  C_WPID,  0, 0, "R9");
        txn(K_IN,    0, 8,  3, 4, 0, P_NAK,   1, 1, 0, 0,  C_NAK,   0, 0, "R9");
        txn(K_IN,    0, 8,  3, 4, 0, P_STALL, 1, 1, 0, 0,  C_STALL, 0, 0, "R9");
        timeout_case();
        txn(K_OUT,   0, 8, 10, 30, 0, P_ACK,  1, 1, 0, 0,  C_OK,    0, 0, "R10");
        txn(K_IN,    0, 8,  2, 2, 1, P_NAK,   1, 1, 0, 0,  C_NAK,   0, 0, "R2");
        check(exp_q.size() == 0, "R11", "pending expectations", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL R11 watchdog expired: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule